// File: doc/BRIEF.md
# A/D Converter Register Interface

This block gives software a word/byte register window onto a multichannel analog-to-digital converter. It has two registers. The first is a control/status register. Software sets the multiplexer channel, the amplifier gain, interrupt enable, the request level and external-clock control there, and issues a start command. The same register reports whether a result is waiting and whether a start came too early. The second is a read-only data register. It holds the last conversion result.

A conversion sequencer outside the block does the conversion. The block gives it a one-cycle start pulse plus the channel, gain and external-clock settings. The sequencer returns a done pulse with the result word. The block latches that word and raises a level interrupt request if software has enabled one. The request stays up until the processor acknowledges it or until software clears its cause. The request carries one of two priority levels.

Top module: `adc_regs`

## Requirements
- R1: After reset, both registers read as zero. `irq_req`, `conv_start`, `chan_sel`, `gain_code` and `ext_clk_en` are all low, and `irq_level` is 7.
- R2: The control/status register is at `BASE_ADDR` and reads as follows. Bit 15 is error. Bits 13:8 are the channel. Bit 7 is done. Bit 6 is interrupt enable. Bits 5:3 are gain. Bit 2 is level select. Bit 1 is external-clock enable. Bits 14 and 0 always read zero.
- R3: Byte enable bit 0 writes bits 6:0 (interrupt enable, gain, level select, external-clock enable, start). Byte enable bit 1 writes only the channel bits 13:8. A byte write leaves the other byte's fields unchanged. Bits 15, 14 and 7 cannot be written.
- R4: A write with byte enable 0 set and data bit 0 set makes `conv_start` high for exactly one cycle, the cycle after the write edge.
- R5: A `conv_done` pulse sets done (bit 7). It also latches `conv_result`, zero-extended to 16 bits, into the data register at `BASE_ADDR`+2.
- R6: Reading the data register clears done. Reading the control/status register does not. A done pulse in the same cycle as the read wins.
- R7: Error (bit 15) sets when a start is written after an earlier start whose result has not yet been read from the data register. This applies whether or not done has arrived.
- R8: Any write to the gain byte or the channel byte clears error. If the same write carries a start that collides under R7, error is set instead.
- R9: Writes to the data register address, and accesses to any other address, change no register and no output.
- R10: `irq_req` is high while interrupt enable is set, done or error is set, and the request is armed. Three events arm it: a done pulse, an error setting, or interrupt enable being written from 0 to 1. A cycle of `irq_ack` disarms it.
- R11: `irq_level` is 7 while level select (bit 2) is clear. It is `ALT_LEVEL` (default 5) while level select is set.
- R12: `chan_sel` follows bits 13:8, `gain_code` follows bits 4:3 (00=x1, 01=x2, 10=x4, 11=x8; bit 5 is reserved and only stored), and `ext_clk_en` follows bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low bus reset |
| bus_sel | input | 1 | Bus cycle addresses this block |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 2 | Byte enables, bit 1 = high byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| conv_start | output | 1 | One-cycle start to the sequencer |
| conv_done | input | 1 | One-cycle conversion-complete pulse |
| conv_result | input | RES_W | Conversion result, valid with conv_done |
| chan_sel | output | 6 | Selected multiplexer channel |
| gain_code | output | 2 | Amplifier gain code |
| ext_clk_en | output | 1 | External clock controls conversions |
| irq_req | output | 1 | Level interrupt request |
| irq_level | output | 3 | Priority level of the request |
| irq_ack | input | 1 | Processor acknowledge |

## Verification
The bench first goes after the error flag's window. Three cases matter. A start after done arrived but before the data read must still flag. A start after the data read must not. A colliding start carried in the same write that reloads gain must set error rather than clear it; a design that let the clear win would hide the overrun. Done must survive reads of the control/status register, and writes to bit 7, bit 15 and the data address must leave state untouched; a decoder that let those writes land would corrupt the result. The bench also checks that an acknowledge drops the request while done is still set, and that enabling interrupts afterwards raises it again; a design that only ORed enable with the flags would fail both.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;

  localparam int CSR_ERR_BIT  = 15;
  localparam int CSR_CHAN_LO  = 8;
  localparam int CHAN_W       = 6;
  localparam int CSR_DONE_BIT = 7;
  localparam int CSR_IE_BIT   = 6;
  localparam int CSR_GAIN_LO  = 3;
  localparam int GAIN_W       = 3;
  localparam int CSR_LVL_BIT  = 2;
  localparam int CSR_EXT_BIT  = 1;
  localparam int CSR_GO_BIT   = 0;
  localparam logic [2:0] TOP_LEVEL = 3'd7;

  typedef struct packed {
    logic              ie;
    logic [GAIN_W-1:0] gain;
    logic              lvl_alt;
    logic              ext;
  } lo_ctrl_t;

  // Assemble the control/status read word from its fields.
  function automatic logic [15:0] pack_csr(input logic err,
                                           input logic [CHAN_W-1:0] chan,
                                           input logic done,
                                           input lo_ctrl_t lo);
    logic [15:0] w;
    w = '0;
    w[CSR_ERR_BIT]                       = err;
    w[CSR_CHAN_LO +: CHAN_W]             = chan;
    w[CSR_DONE_BIT]                      = done;
    w[CSR_IE_BIT]                        = lo.ie;
    w[CSR_GAIN_LO +: GAIN_W]             = lo.gain;
    w[CSR_LVL_BIT]                       = lo.lvl_alt;
    w[CSR_EXT_BIT]                       = lo.ext;
    return w;
  endfunction

  // Pick the request level from the select bit.
  function automatic logic [2:0] pick_level(input logic alt, input logic [2:0] alt_lvl);
    return alt ? alt_lvl : TOP_LEVEL;
  endfunction

endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode #(
  parameter int          ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFDF8
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  output logic              csr_wr_lo,
  output logic              csr_wr_hi,
  output logic              csr_rd,
  output logic              dbr_rd
);
  localparam logic [ADDR_W-1:0] DBR_ADDR = BASE_ADDR + ADDR_W'(2);

  logic hit_csr, hit_dbr;
  logic unused_addr0;

  assign unused_addr0 = bus_addr[0];
  assign hit_csr = bus_sel && (bus_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign hit_dbr = bus_sel && (bus_addr[ADDR_W-1:1] == DBR_ADDR[ADDR_W-1:1]);

  assign csr_wr_lo = hit_csr && bus_wr && bus_be[0];
  assign csr_wr_hi = hit_csr && bus_wr && bus_be[1];
  assign csr_rd    = hit_csr && bus_rd && !bus_wr;
  assign dbr_rd    = hit_dbr && bus_rd && !bus_wr;
endmodule

// File: rtl/adc_ctrl_fields.sv
module adc_ctrl_fields
  import adc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr_lo,
  input  logic              csr_wr_hi,
  input  logic [6:0]        wdata_lo,
  input  logic [CHAN_W-1:0] wdata_chan,
  output lo_ctrl_t          lo_ctrl,
  output logic [CHAN_W-1:0] chan,
  output logic              start_wr,
  output logic              ie_rise,
  output logic              conv_start
);
  lo_ctrl_t lo_next;

  assign lo_next.ie      = wdata_lo[CSR_IE_BIT];
  assign lo_next.gain    = wdata_lo[CSR_GAIN_LO +: GAIN_W];
  assign lo_next.lvl_alt = wdata_lo[CSR_LVL_BIT];
  assign lo_next.ext     = wdata_lo[CSR_EXT_BIT];

  assign start_wr = csr_wr_lo && wdata_lo[CSR_GO_BIT];
  assign ie_rise  = csr_wr_lo && lo_next.ie && !lo_ctrl.ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_ctrl    <= '0;
      chan       <= '0;
      conv_start <= 1'b0;
    end else begin
      if (csr_wr_lo) lo_ctrl <= lo_next;
      if (csr_wr_hi) chan    <= wdata_chan;
      conv_start <= start_wr;
    end
  end
endmodule

// File: rtl/adc_status_track.sv
module adc_status_track #(
  parameter int RES_W   = 10,
  parameter bit BIPOLAR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             csr_wr_lo,
  input  logic             csr_wr_hi,
  input  logic             dbr_rd,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             done_flag,
  output logic             err_flag,
  output logic             outstanding,
  output logic             err_set,
  output logic [15:0]      dbr_val
);
  localparam int PAD_W = 16 - RES_W;

  logic [15:0] result_ext;

  generate
    if (BIPOLAR) begin : g_signed
      assign result_ext = {{PAD_W{conv_result[RES_W-1]}}, conv_result};
    end else begin : g_unsigned
      assign result_ext = {{PAD_W{1'b0}}, conv_result};
    end
  endgenerate

  assign err_set = start_wr && outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag   <= 1'b0;
      err_flag    <= 1'b0;
      outstanding <= 1'b0;
      dbr_val     <= '0;
    end else begin
      if (conv_done) begin
        done_flag <= 1'b1;
        dbr_val   <= result_ext;
      end else if (dbr_rd) begin
        done_flag <= 1'b0;
      end

      if (start_wr)    outstanding <= 1'b1;
      else if (dbr_rd) outstanding <= 1'b0;

      if (err_set)                     err_flag <= 1'b1;
      else if (csr_wr_lo || csr_wr_hi) err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_irq_gen.sv
module adc_irq_gen
  import adc_regs_pkg::*;
#(
  parameter logic [2:0] ALT_LEVEL = 3'd5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ie,
  input  logic       done_flag,
  input  logic       err_flag,
  input  logic       arm_set,
  input  logic       irq_ack,
  input  logic       lvl_alt,
  output logic       irq_req,
  output logic [2:0] irq_level
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (arm_set) armed <= 1'b1;
    else if (irq_ack) armed <= 1'b0;
  end

  assign irq_req   = armed && ie && (done_flag || err_flag);
  assign irq_level = pick_level(lvl_alt, ALT_LEVEL);
endmodule

// File: rtl/adc_regs.sv
module adc_regs
  import adc_regs_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFDF8,
  parameter int                RES_W     = 10,
  parameter bit                BIPOLAR   = 1'b0,
  parameter logic [2:0]        ALT_LEVEL = 3'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic [5:0]        chan_sel,
  output logic [1:0]        gain_code,
  output logic              ext_clk_en,
  output logic              irq_req,
  output logic [2:0]        irq_level,
  input  logic              irq_ack
);
  logic        csr_wr_lo, csr_wr_hi, csr_rd, dbr_rd;
  logic        start_wr, ie_rise, err_set, arm_set;
  logic        done_flag, err_flag, outstanding;
  logic [15:0] dbr_val;
  lo_ctrl_t    lo_ctrl;
  logic [CHAN_W-1:0] chan;
  logic        unused_wbits;

  assign unused_wbits = ^{bus_wdata[15:14], bus_wdata[7]};

  adc_bus_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be),
    .csr_wr_lo(csr_wr_lo), .csr_wr_hi(csr_wr_hi),
    .csr_rd(csr_rd), .dbr_rd(dbr_rd)
  );

  adc_ctrl_fields u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .csr_wr_lo(csr_wr_lo), .csr_wr_hi(csr_wr_hi),
    .wdata_lo(bus_wdata[6:0]), .wdata_chan(bus_wdata[CSR_CHAN_LO +: CHAN_W]),
    .lo_ctrl(lo_ctrl), .chan(chan),
    .start_wr(start_wr), .ie_rise(ie_rise), .conv_start(conv_start)
  );

  adc_status_track #(.RES_W(RES_W), .BIPOLAR(BIPOLAR)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .start_wr(start_wr), .csr_wr_lo(csr_wr_lo), .csr_wr_hi(csr_wr_hi),
    .dbr_rd(dbr_rd), .conv_done(conv_done), .conv_result(conv_result),
    .done_flag(done_flag), .err_flag(err_flag), .outstanding(outstanding),
    .err_set(err_set), .dbr_val(dbr_val)
  );

  assign arm_set = conv_done || err_set || ie_rise;

  adc_irq_gen #(.ALT_LEVEL(ALT_LEVEL)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .ie(lo_ctrl.ie), .done_flag(done_flag), .err_flag(err_flag),
    .arm_set(arm_set), .irq_ack(irq_ack), .lvl_alt(lo_ctrl.lvl_alt),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  always_comb begin
    bus_rdata = '0;
    if (csr_rd)      bus_rdata = pack_csr(err_flag, chan, done_flag, lo_ctrl);
    else if (dbr_rd) bus_rdata = dbr_val;
  end

  assign chan_sel   = chan;
  assign gain_code  = lo_ctrl.gain[1:0];
  assign ext_clk_en = lo_ctrl.ext;
endmodule

// File: rtl/adc_regs_chk.sv
module adc_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        conv_start,
  input logic        start_wr,
  input logic        outstanding,
  input logic        conv_done,
  input logic        done_flag,
  input logic        dbr_rd,
  input logic        err_flag,
  input logic        irq_req,
  input logic        irq_ack,
  input logic        arm_set,
  input logic [15:0] dbr_val
);
  assert_start_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !start_wr) |=> !conv_start);

  assert_start_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> conv_start);

  assert_done_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> done_flag);

  assert_read_clears_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbr_rd && !conv_done) |=> !done_flag);

  assert_overrun_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && outstanding) |=> err_flag);

  assert_dbr_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(dbr_val));

  assert_req_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (done_flag || err_flag));

  assert_ack_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !arm_set) |=> !irq_req);
endmodule

bind adc_regs adc_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .start_wr(start_wr),
  .outstanding(outstanding), .conv_done(conv_done), .done_flag(done_flag),
  .dbr_rd(dbr_rd), .err_flag(err_flag), .irq_req(irq_req), .irq_ack(irq_ack),
  .arm_set(arm_set), .dbr_val(dbr_val)
);

// File: tb/adc_regs_tb.sv
`timescale 1ns/1ps
module adc_regs_tb;
  localparam logic [15:0] CSR_A = 16'hFDF8;
  localparam logic [15:0] DBR_A = 16'hFDFA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        conv_start, conv_done = 1'b0;
  logic [9:0]  conv_result = '0;
  logic [5:0]  chan_sel;
  logic [1:0]  gain_code;
  logic        ext_clk_en, irq_req, irq_ack = 1'b0;
  logic [2:0]  irq_level;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic last_start;

  always #10 clk = ~clk;

  adc_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result),
    .chan_sel(chan_sel), .gain_code(gain_code), .ext_clk_en(ext_clk_en),
    .irq_req(irq_req), .irq_level(irq_level), .irq_ack(irq_ack)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk); #2 last_start = conv_start;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic done_pulse(input logic [9:0] r);
    @(negedge clk); conv_done = 1; conv_result = r;
    @(negedge clk); conv_done = 0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(CSR_A, d); check("R1 csr", d, 16'h0000);
    rd(DBR_A, d); check("R1 dbr", d, 16'h0000);
    check("R1 irq", {15'd0, irq_req}, 16'd0);
    check("R1 start", {15'd0, conv_start}, 16'd0);
    check("R1 outs", {7'd0, chan_sel, gain_code, ext_clk_en}, 16'd0);
    check("R1 level", {13'd0, irq_level}, 16'd7);
  endtask

  task automatic t_word_rw();
    logic [15:0] d;
    wr(CSR_A, 2'b11, 16'hFFFE);
    rd(CSR_A, d); check("R2 all ones", d, 16'h3F7E);
    check("R12 chan", {10'd0, chan_sel}, 16'h003F);
    check("R12 gain", {14'd0, gain_code}, 16'd3);
    check("R12 ext", {15'd0, ext_clk_en}, 16'd1);
    check("R10 no cause", {15'd0, irq_req}, 16'd0);
    wr(CSR_A, 2'b11, 16'h1558);
    rd(CSR_A, d); check("R2 pattern", d, 16'h1558);
    check("R12 gain x8", {14'd0, gain_code}, 16'd3);
    check("R11 level 7", {13'd0, irq_level}, 16'd7);
  endtask

  task automatic t_byte();
    logic [15:0] d;
    wr(CSR_A, 2'b11, 16'h0000);
    wr(CSR_A, 2'b01, 16'hFF2C);
    rd(CSR_A, d); check("R3 low byte only", d, 16'h002C);
    check("R12 gain reserved", {14'd0, gain_code}, 16'd1);
    check("R11 level alt", {13'd0, irq_level}, 16'd5);
    wr(CSR_A, 2'b10, 16'hCAFF);
    rd(CSR_A, d); check("R3 high byte only", d, 16'h0A2C);
  endtask

  task automatic t_start_done();
    logic [15:0] d;
    wr(CSR_A, 2'b01, 16'h0001);
    check("R4 start pulse", {15'd0, last_start}, 16'd1);
    @(posedge clk); #2 check("R4 single cycle", {15'd0, conv_start}, 16'd0);
    rd(CSR_A, d); check("R4 go reads zero", d, 16'h0A00);
    done_pulse(10'h2AB);
    rd(CSR_A, d); check("R5 done set", d, 16'h0A80);
    wr(CSR_A, 2'b01, 16'h0000);
    rd(CSR_A, d); check("R6 csr read keeps done", d, 16'h0A80);
    rd(DBR_A, d); check("R5 result", d, 16'h02AB);
    rd(CSR_A, d); check("R6 dbr read clears done", d, 16'h0A00);
    wr(CSR_A, 2'b01, 16'h0080);
    rd(CSR_A, d); check("R3 done not writable", d, 16'h0A00);
  endtask

  task automatic t_error();
    logic [15:0] d;
    wr(CSR_A, 2'b01, 16'h0001);
    wr(CSR_A, 2'b01, 16'h0001);
    rd(CSR_A, d); check("R7 overrun", d, 16'h8A00);
    wr(CSR_A, 2'b10, 16'h0B00);
    rd(CSR_A, d); check("R8 chan load clears", d, 16'h0B00);
    wr(CSR_A, 2'b01, 16'h0001);
    rd(CSR_A, d); check("R8 set wins", d, 16'h8B00);
    done_pulse(10'h011);
    rd(DBR_A, d);
    wr(CSR_A, 2'b01, 16'h0000);
    rd(CSR_A, d); check("R8 gain load clears", d, 16'h0B00);
    wr(CSR_A, 2'b01, 16'h0001);
    rd(CSR_A, d); check("R7 start after read ok", d, 16'h0B00);
    done_pulse(10'h3FF);
    wr(CSR_A, 2'b01, 16'h0001);
    rd(CSR_A, d); check("R7 done but unread", d, 16'h8B80);
    done_pulse(10'h155);
    rd(DBR_A, d); check("R5 latest result", d, 16'h0155);
    wr(CSR_A, 2'b11, 16'h0B00);
  endtask

  task automatic t_ignore();
    logic [15:0] d;
    done_pulse(10'h123);
    wr(DBR_A, 2'b11, 16'hFFFF);
    wr(CSR_A + 16'd4, 2'b11, 16'hFFFF);
    check("R9 no start", {15'd0, last_start}, 16'd0);
    rd(CSR_A, d); check("R9 csr untouched", d, 16'h0B80);
    rd(DBR_A, d); check("R9 dbr untouched", d, 16'h0123);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(CSR_A, 2'b01, 16'h0040);
    check("R10 enable no cause", {15'd0, irq_req}, 16'd0);
    wr(CSR_A, 2'b01, 16'h0041);
    done_pulse(10'h004);
    check("R10 done irq", {15'd0, irq_req}, 16'd1);
    check("R11 level 7", {13'd0, irq_level}, 16'd7);
    ack_pulse();
    check("R10 ack drops", {15'd0, irq_req}, 16'd0);
    rd(DBR_A, d);
    wr(CSR_A, 2'b01, 16'h0045);
    wr(CSR_A, 2'b01, 16'h0045);
    check("R10 error irq", {15'd0, irq_req}, 16'd1);
    check("R11 level alt", {13'd0, irq_level}, 16'd5);
    wr(CSR_A, 2'b01, 16'h0044);
    check("R10 cause cleared", {15'd0, irq_req}, 16'd0);
    wr(CSR_A, 2'b01, 16'h0000);
    done_pulse(10'h001);
    check("R10 disabled", {15'd0, irq_req}, 16'd0);
    wr(CSR_A, 2'b01, 16'h0040);
    check("R10 enable rearms", {15'd0, irq_req}, 16'd1);
    rd(DBR_A, d);
    check("R10 read clears", {15'd0, irq_req}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_word_rw();
    t_byte();
    t_start_done();
    t_error();
    t_ignore();
    t_irq();
    finish_run();
  end
endmodule